// File: doc/BRIEF.md
# SPI Serial Memory Slave Controller

This block is the serial slave front end of a byte-wide memory. A host frames each transaction with an active-low chip select. The first byte after chip select goes low is a command. Memory reads and writes then take a 16-bit address, most significant byte first, and stream data bytes from that address onward. The address advances after every byte and wraps at the top of the array.

A write-enable flag and a two-bit protection field guard every store. Both the memory array and the protection field ignore writes unless the flag was armed beforehand. The protection field also fences off an upper part of the array. Stores finish in the same serial bit period as the last data bit, so a read may start in the very next transaction.

The serial pins are oversampled by the block's own clock. The serial output comes with an enable that an outside pad uses as its tristate control. The array is an internal synchronous RAM of `2**ADDR_W` bytes. `ADDR_W = 15` gives the 32K x 8 organisation that wraps at 0x7FFF. Address bits above `ADDR_W` are ignored.

Top module: `spi_mem_slave`

## Requirements
- R1: After each falling edge of `cs_n`, the first byte is the command. Commands 0x03 (read) and 0x02 (write) are followed by two address bytes, high byte first, and the low `ADDR_W` bits select the starting byte.
- R2: `mosi` is sampled on rising edges of `sck`, and `miso` changes on falling edges. It works whether `sck` idles low (mode 0) or high (mode 3) when `cs_n` falls. Bits are shifted most significant first.
- R3: During a read or write burst, the address steps by one after every complete data byte and wraps from `2**ADDR_W-1` to 0 (0x7FFF to 0x0000 when `ADDR_W = 15`).
- R4: `miso_oe` is high only from the first falling `sck` edge of read or status data until `cs_n` rises. It is low during command, address and write bytes and while `cs_n` is high.
- R5: Command 0x06 sets the write-enable flag as soon as its byte completes. Command 0x04 clears it.
- R6: Memory data bytes and status writes are discarded while the write-enable flag is clear.
- R7: The write-enable flag clears when `cs_n` rises after a 0x02 or 0x01 command byte was received.
- R8: Command 0x05 shifts out the status byte `{4'b0000, prot[1:0], wen, 1'b0}`: the protection field in bits 3:2 and the write-enable flag in bit 1. It repeats for as long as clocks continue.
- R9: Command 0x01 loads the protection field from bits 3:2 of each complete data byte. All other bits of that byte are ignored.
- R10: The protection field selects the locked region for memory writes. 00 locks nothing. 01 locks addresses whose two top bits are 11. 10 locks addresses whose top bit is 1. 11 locks the whole array. Locked bytes are discarded, and the address still advances.
- R11: If `cs_n` rises part way through a byte, the command ends and that partial byte is never written.
- R12: After reset, the write-enable flag and protection field are 0 and `miso_oe` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data into the block |
| miso | output | 1 | Serial data out of the block |
| miso_oe | output | 1 | Output enable for the `miso` pad driver |

## Verification
The assertions assume the host never moves `sck` in the same block-clock sample as `cs_n`. They also assume each `sck` level lasts several block clocks, longer than the synchronizer depth plus one. Otherwise edge events could merge and the one-event-per-cycle property would not hold. The stimulus drives all serial pins on falling edges of the block clock and holds every `sck` phase for eight clocks. It leaves a quiet gap of several clocks around each chip-select change, so every edge reaches the controller as a separate, ordered event.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

  localparam logic [7:0] OP_WEN_SET = 8'h06;
  localparam logic [7:0] OP_WEN_CLR = 8'h04;
  localparam logic [7:0] OP_STAT_RD = 8'h05;
  localparam logic [7:0] OP_STAT_WR = 8'h01;
  localparam logic [7:0] OP_MEM_RD  = 8'h03;
  localparam logic [7:0] OP_MEM_WR  = 8'h02;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_ADDR,
    ST_RD,
    ST_WR,
    ST_SR_RD,
    ST_SR_WR,
    ST_SKIP
  } mem_state_t;

  // Locked-region decode from the protection field and the two top address bits.
  function automatic logic region_locked(input logic [1:0] prot, input logic [1:0] top2);
    case (prot)
      2'b00:   return 1'b0;
      2'b01:   return (top2 == 2'b11);
      2'b10:   return top2[1];
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [7:0] status_byte(input logic [1:0] prot, input logic wen);
    return {4'b0000, prot, wen, 1'b0};
  endfunction

endpackage

// File: rtl/spi_mem_sync.sv
module spi_mem_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic mosi,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_fall,
  output logic cs_rise,
  output logic cs_active,
  output logic mosi_s
);
  // pipe bit order: {sck, cs_n, mosi}; chip select idles high
  localparam logic [2:0] PIPE_RST = 3'b010;

  logic [2:0] pipe [STAGES];
  logic       sck_q;
  logic       cs_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[0] <= PIPE_RST;
        else        pipe[0] <= {sck, cs_n, mosi};
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[g] <= PIPE_RST;
        else        pipe[g] <= pipe[g-1];
      end
    end
  end

  logic [2:0] last;
  assign last = pipe[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
    end else begin
      sck_q <= last[2];
      cs_q  <= last[1];
    end
  end

  assign cs_active = ~last[1];
  assign sck_rise  = cs_active &  last[2] & ~sck_q;
  assign sck_fall  = cs_active & ~last[2] &  sck_q;
  assign cs_fall   =  cs_q & ~last[1];
  assign cs_rise   = ~cs_q &  last[1];
  assign mosi_s    = last[0];

  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sck_rise, sck_fall, cs_fall, cs_rise})); // R2

endmodule

// File: rtl/spi_mem_ram.sv
module spi_mem_ram #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end

  AST_WADDR_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> !$isunknown(addr)); // R1

endmodule

// File: rtl/spi_mem_ctrl.sv
module spi_mem_ctrl
  import spi_mem_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              cs_fall,
  input  logic              cs_rise,
  input  logic              cs_active,
  input  logic              mosi_s,
  input  logic [7:0]        ram_rdata,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [7:0]        ram_wdata,
  output logic              miso,
  output logic              miso_oe
);

  function automatic logic [ADDR_W-1:0] addr_next(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  mem_state_t        state;
  logic [2:0]        bit_cnt;
  logic [6:0]        rx_sh;
  logic [7:0]        addr_hi;
  logic              addr_phase;
  logic              is_read;
  logic [ADDR_W-1:0] addr;
  logic              wen;
  logic [1:0]        prot;
  logic [7:0]        tx_sh;
  logic              tx_live;
  logic              wr_cmd_seen;

  // named internal events
  logic       byte_done;
  logic [7:0] rx_byte;
  logic       tx_phase;
  logic       locked;
  logic [7:0] tx_load;

  assign byte_done = sck_rise && (bit_cnt == 3'd7);
  assign rx_byte   = {rx_sh, mosi_s};
  assign tx_phase  = sck_fall && (state == ST_RD || state == ST_SR_RD);
  assign locked    = region_locked(prot, addr[ADDR_W-1 -: 2]);
  assign tx_load   = (state == ST_SR_RD) ? status_byte(prot, wen) : ram_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      bit_cnt     <= '0;
      rx_sh       <= '0;
      addr_hi     <= '0;
      addr_phase  <= 1'b0;
      is_read     <= 1'b0;
      addr        <= '0;
      wen         <= 1'b0;
      prot        <= 2'b00;
      tx_sh       <= '0;
      tx_live     <= 1'b0;
      wr_cmd_seen <= 1'b0;
    end else if (cs_fall) begin
      state       <= ST_CMD;
      bit_cnt     <= '0;
      addr_phase  <= 1'b0;
      tx_live     <= 1'b0;
      wr_cmd_seen <= 1'b0;
    end else if (cs_rise) begin
      state   <= ST_IDLE;
      tx_live <= 1'b0;
      if (wr_cmd_seen) wen <= 1'b0;
    end else begin
      if (sck_rise) begin
        rx_sh   <= {rx_sh[5:0], mosi_s};
        bit_cnt <= bit_cnt + 3'd1;
      end
      if (byte_done) begin
        case (state)
          ST_CMD: begin
            case (rx_byte)
              OP_WEN_SET: begin wen <= 1'b1; state <= ST_SKIP; end
              OP_WEN_CLR: begin wen <= 1'b0; state <= ST_SKIP; end
              OP_STAT_RD: state <= ST_SR_RD;
              OP_STAT_WR: begin state <= ST_SR_WR; wr_cmd_seen <= 1'b1; end
              OP_MEM_RD:  begin state <= ST_ADDR; is_read <= 1'b1; end
              OP_MEM_WR:  begin state <= ST_ADDR; is_read <= 1'b0; wr_cmd_seen <= 1'b1; end
              default:    state <= ST_SKIP;
            endcase
          end
          ST_ADDR: begin
            if (!addr_phase) begin
              addr_hi    <= rx_byte;
              addr_phase <= 1'b1;
            end else begin
              addr  <= ADDR_W'({addr_hi, rx_byte});
              state <= is_read ? ST_RD : ST_WR;
            end
          end
          ST_SR_WR: if (wen) prot <= rx_byte[3:2];
          ST_RD, ST_WR: addr <= addr_next(addr);
          default: ;
        endcase
      end
      if (tx_phase) begin
        if (bit_cnt == 3'd0) begin
          tx_sh   <= tx_load;
          tx_live <= 1'b1;
        end else begin
          tx_sh <= {tx_sh[6:0], 1'b0};
        end
      end
    end
  end

  assign ram_we    = byte_done && (state == ST_WR) && wen && !locked;
  assign ram_addr  = addr;
  assign ram_wdata = rx_byte;
  assign miso      = tx_sh[7];
  assign miso_oe   = tx_live && cs_active;

  AST_OE_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    miso_oe |-> (state == ST_RD || state == ST_SR_RD)); // R4

  AST_WE_AFTER_WR_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> wr_cmd_seen); // R6

  AST_WEN_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && wr_cmd_seen) |=> !wen); // R7

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && !cs_fall && !cs_rise && (state == ST_RD || state == ST_WR))
      |=> addr == addr_next($past(addr))); // R3

endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave #(
  parameter int ADDR_W      = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic mosi,
  output logic miso,
  output logic miso_oe
);
  logic              sck_rise;
  logic              sck_fall;
  logic              cs_fall;
  logic              cs_rise;
  logic              cs_active;
  logic              mosi_s;
  logic              ram_we;
  logic [ADDR_W-1:0] ram_addr;
  logic [7:0]        ram_wdata;
  logic [7:0]        ram_rdata;

  spi_mem_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .sck       (sck),
    .cs_n      (cs_n),
    .mosi      (mosi),
    .sck_rise  (sck_rise),
    .sck_fall  (sck_fall),
    .cs_fall   (cs_fall),
    .cs_rise   (cs_rise),
    .cs_active (cs_active),
    .mosi_s    (mosi_s)
  );

  spi_mem_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .sck_rise  (sck_rise),
    .sck_fall  (sck_fall),
    .cs_fall   (cs_fall),
    .cs_rise   (cs_rise),
    .cs_active (cs_active),
    .mosi_s    (mosi_s),
    .ram_rdata (ram_rdata),
    .ram_we    (ram_we),
    .ram_addr  (ram_addr),
    .ram_wdata (ram_wdata),
    .miso      (miso),
    .miso_oe   (miso_oe)
  );

  spi_mem_ram #(.ADDR_W(ADDR_W), .DATA_W(8)) u_ram (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (ram_we),
    .addr  (ram_addr),
    .wdata (ram_wdata),
    .rdata (ram_rdata)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_active |-> !miso_oe); // R4

endmodule

// File: tb/spi_mem_slave_test.sv
module spi_mem_slave_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0;
  logic cs_n = 1'b1;
  logic mosi = 1'b0;
  logic miso;
  logic miso_oe;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  bit mode3 = 0;
  localparam int HALF = 8;

  always #2 clk = ~clk;

  spi_mem_slave #(.ADDR_W(15), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n),
    .mosi(mosi), .miso(miso), .miso_oe(miso_oe)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_start();
    sck = mode3 ? 1'b1 : 1'b0;
    wait_clk(4);
    cs_n = 1'b0;
    wait_clk(4);
  endtask

  task automatic spi_stop();
    if (!mode3) begin
      sck = 1'b0;
      wait_clk(HALF);
    end
    wait_clk(4);
    cs_n = 1'b1;
    wait_clk(HALF);
  endtask

  task automatic spi_bits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - nbits; i--) begin
      sck  = 1'b0;
      mosi = tx[i];
      wait_clk(HALF);
      rx[i] = miso;
      sck = 1'b1;
      wait_clk(HALF);
    end
  endtask

  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
    spi_bits(tx, 8, rx);
  endtask

  task automatic cmd_only(input logic [7:0] op);
    logic [7:0] d;
    spi_start();
    spi_byte(op, d);
    spi_stop();
  endtask

  task automatic read_status(output logic [7:0] s);
    logic [7:0] d;
    spi_start();
    spi_byte(8'h05, d);
    spi_byte(8'h00, s);
    spi_stop();
  endtask

  task automatic write_burst(input logic [15:0] a, input logic [7:0] b0, input logic [7:0] b1,
                             input int n);
    logic [7:0] d;
    spi_start();
    spi_byte(8'h02, d);
    spi_byte(a[15:8], d);
    spi_byte(a[7:0], d);
    spi_byte(b0, d);
    checks++;
    if (miso_oe !== 1'b0) begin
      errors++;
      $display("FAIL R4: oe during write got %b expected 0", miso_oe);
    end
    if (n > 1) spi_byte(b1, d);
    spi_stop();
  endtask

  task automatic read_burst(input logic [15:0] a, output logic [7:0] r0, output logic [7:0] r1);
    logic [7:0] d;
    spi_start();
    spi_byte(8'h03, d);
    spi_byte(a[15:8], d);
    spi_byte(a[7:0], d);
    spi_byte(8'h00, r0);
    check("R4 oe while reading", {7'b0, miso_oe}, 8'h01);
    spi_byte(8'h00, r1);
    spi_stop();
    check("R4 oe after cs high", {7'b0, miso_oe}, 8'h00);
  endtask

  task automatic set_prot(input logic [1:0] p);
    logic [7:0] d;
    cmd_only(8'h06);
    spi_start();
    spi_byte(8'h01, d);
    spi_byte({4'hF, p, 2'b11}, d);
    spi_stop();
  endtask

  function automatic bit locked_ref(input int p, input int a);
    return (p == 3) || (p == 2 && a >= 16384) || (p == 1 && a >= 24576);
  endfunction

  task automatic t_reset();
    logic [7:0] s;
    check("R12 oe after reset", {7'b0, miso_oe}, 8'h00);
    read_status(s);
    check("R12 status after reset", s, 8'h00);
  endtask

  task automatic t_wen();
    logic [7:0] s;
    cmd_only(8'h06);
    read_status(s);
    check("R5 R8 status after set", s, 8'h02);
    cmd_only(8'h04);
    read_status(s);
    check("R5 status after clear", s, 8'h00);
  endtask

  task automatic t_write_read();
    logic [7:0] r0, r1, s;
    cmd_only(8'h06);
    write_burst(16'h0010, 8'h11, 8'h22, 2);
    read_status(s);
    check("R7 wen cleared after write", s, 8'h00);
    read_burst(16'h0010, r0, r1);
    check("R1 first byte", r0, 8'h11);
    check("R3 incremented byte", r1, 8'h22);
    write_burst(16'h0010, 8'hFF, 8'hEE, 2);
    read_burst(16'h0010, r0, r1);
    check("R6 write without wen dropped", r0, 8'h11);
    check("R6 second byte kept", r1, 8'h22);
    mode3 = 1;
    read_burst(16'h8010, r0, r1);
    check("R2 mode 3 read, top addr bit ignored R1", r0, 8'h11);
    check("R2 mode 3 second byte", r1, 8'h22);
    cmd_only(8'h06);
    write_burst(16'h0020, 8'h5C, 8'h00, 1);
    mode3 = 0;
    read_burst(16'h0020, r0, r1);
    check("R2 mode 3 write seen in mode 0", r0, 8'h5C);
  endtask

  task automatic t_wrap();
    logic [7:0] r0, r1;
    cmd_only(8'h06);
    write_burst(16'h7FFF, 8'hAA, 8'hBB, 2);
    read_burst(16'h0000, r0, r1);
    check("R3 wrap to zero", r0, 8'hBB);
    read_burst(16'h7FFF, r0, r1);
    check("R3 top byte", r0, 8'hAA);
    check("R3 read wraps", r1, 8'hBB);
  endtask

  task automatic t_status_write();
    logic [7:0] s;
    set_prot(2'b01);
    read_status(s);
    check("R9 field loaded, other bits ignored, R7 wen clear", s, 8'h04);
    spi_start();
    spi_byte(8'h01, s);
    spi_byte(8'h0C, s);
    spi_stop();
    read_status(s);
    check("R6 status write without wen", s, 8'h04);
    set_prot(2'b00);
    read_status(s);
    check("R9 field cleared", s, 8'h00);
  endtask

  task automatic t_protect();
    logic [7:0] r0, r1;
    int starts [3] = '{16'h0100, 16'h3FFF, 16'h5FFF};
    for (int p = 1; p < 4; p++) begin
      set_prot(2'b00);
      foreach (starts[k]) begin
        cmd_only(8'h06);
        write_burst(16'(starts[k]), 8'(p), 8'(p), 2);
      end
      set_prot(2'(p));
      foreach (starts[k]) begin
        cmd_only(8'h06);
        write_burst(16'(starts[k]), 8'hC0 + 8'(p), 8'hC0 + 8'(p), 2);
      end
      foreach (starts[k]) begin
        read_burst(16'(starts[k]), r0, r1);
        check($sformatf("R10 prot %0d addr %h", p, starts[k]), r0,
              locked_ref(p, starts[k]) ? 8'(p) : 8'hC0 + 8'(p));
        check($sformatf("R10 prot %0d addr %h", p, starts[k] + 1), r1,
              locked_ref(p, starts[k] + 1) ? 8'(p) : 8'hC0 + 8'(p));
      end
    end
    set_prot(2'b00);
  endtask

  task automatic t_abort();
    logic [7:0] d, r0, r1;
    cmd_only(8'h06);
    write_burst(16'h0200, 8'h77, 8'h77, 2);
    cmd_only(8'h06);
    spi_start();
    spi_byte(8'h02, d);
    spi_byte(8'h02, d);
    spi_byte(8'h00, d);
    spi_byte(8'h5A, d);
    spi_bits(8'h3C, 4, d);
    spi_stop();
    read_burst(16'h0200, r0, r1);
    check("R11 full byte kept", r0, 8'h5A);
    check("R11 partial byte dropped", r1, 8'h77);
    read_status(d);
    check("R7 wen cleared after abort", d, 8'h00);
  endtask

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    t_reset();
    t_wen();
    t_write_read();
    t_wrap();
    t_status_write();
    t_protect();
    t_abort();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule